// File: doc/BRIEF.md
# Masked Vector Unit with Indexed Gather and Scatter

The block is a serial vector execution unit built around a small register file of fixed-length integer vectors (by default eight registers of eight 16-bit elements). A command names an operation and four register selectors: destination, first source, second source and a selector register. The selector register acts as a per-element predicate for the masked add and as an index vector for gather and scatter. The unit walks the vector one element per clock, writing results back into the register file or folding them into a 32-bit dot-product accumulator. It raises `done` for a single cycle after the run ends.

A host loads and inspects vector registers through a word-wide port while the unit is idle. Operations run strictly in element order, from index 0 up to the last one. A later element therefore sees writes made by earlier elements of the same run. This order also decides which write survives when two scatter indices collide.

Top module: `mvu_top`

## Requirements
- R1: Opcode 0 (add) writes dst[i] = srcA[i] + srcB[i] for every element, wrapping modulo 2^16.
- R2: Opcode 1 (multiply) writes dst[i] = low 16 bits of the unsigned product srcA[i] * srcB[i].
- R3: Opcode 2 (dot) clears the accumulator at launch, adds the unsigned 32-bit product srcA[i] * srcB[i] for every element (wrapping modulo 2^32), writes no register, and leaves `acc_out` holding the sum. No other opcode changes `acc_out`.
- R4: Opcode 3 (masked add) writes dst[i] = srcA[i] + srcB[i] only where sel[i] is nonzero. Elements where sel[i] is zero keep their old value.
- R5: Opcode 4 (scatter add) writes srcA[i] + srcB[i] into dst at position (sel[i] mod VLEN), taken from the low index bits. Positions that no index names are left unchanged.
- R6: When two scatter indices name the same destination, the element with the higher i determines the final value.
- R7: Opcode 5 (gather add) writes dst[i] = srcA[sel[i] mod VLEN] + srcB[i].
- R8: A `cmd_start` sampled while idle raises `busy` on the next cycle. `busy` stays high for exactly VLEN cycles. `done` is high for exactly one cycle, the first cycle with `busy` low.
- R9: A `cmd_start` sampled while busy is ignored. No register is written by it and the running operation keeps its timing.
- R10: A host write (`host_we`) updates element `host_idx` of register `host_reg` only while idle. `host_rdata` shows that element one cycle after the address is presented. A host write while busy has no effect.
- R11: After reset, `busy`, `done` and `acc_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Launch request, taken only while idle |
| cmd_op | input | 3 | Opcode (0 add, 1 mul, 2 dot, 3 masked add, 4 scatter add, 5 gather add) |
| cmd_dst | input | 3 | Destination register |
| cmd_srca | input | 3 | First source register (gathered for opcode 5) |
| cmd_srcb | input | 3 | Second source register |
| cmd_sel | input | 3 | Mask or index register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | 32 | Dot-product accumulator |
| host_we | input | 1 | Host element write strobe |
| host_reg | input | 3 | Host register select |
| host_idx | input | 3 | Host element select |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered read data for the host address |

## Verification
The assertions assume the host uses its port only while the unit is idle, apart from writes that are meant to be dropped. They also assume opcodes 6 and 7 are never issued. The bench launches every operation from the idle state and waits for `done` before it reads results back. It issues extra launches and host writes during a run only to show that they are ignored. Index vectors hold values above VLEN and repeated indices, so that the modulo and collision rules are both exercised.

// File: rtl/mvu_pkg.sv
package mvu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_MUL  = 3'd1,
    OP_DOT  = 3'd2,
    OP_MADD = 3'd3,
    OP_SCAT = 3'd4,
    OP_GATH = 3'd5
  } mvu_op_e;
endpackage

// File: rtl/mvu_vrf.sv
// Vector register file: flat element memory, combinational operand ports,
// one write port, one registered host read port.
module mvu_vrf #(
  parameter int DEPTH = 64,
  parameter int EW    = 16,
  parameter int NRD   = 3,
  localparam int DAW  = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic [NRD-1:0][DAW-1:0]  rd_addr,
  output logic [NRD-1:0][EW-1:0]   rd_data,
  input  logic                     wr_en,
  input  logic [DAW-1:0]           wr_addr,
  input  logic [EW-1:0]            wr_data,
  input  logic [DAW-1:0]           hr_addr,
  output logic [EW-1:0]            hr_data
);
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    hr_data <= mem[hr_addr];
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = mem[rd_addr[p]];
  end
endmodule

// File: rtl/mvu_seq.sv
// Run controller: latches a command while idle and steps the element index.
module mvu_seq
  import mvu_pkg::*;
#(
  parameter int VLEN = 8,
  parameter int RSW  = 3,
  localparam int IW  = (VLEN > 1) ? $clog2(VLEN) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_start,
  input  mvu_op_e        cmd_op,
  input  logic [RSW-1:0] cmd_dst,
  input  logic [RSW-1:0] cmd_srca,
  input  logic [RSW-1:0] cmd_srcb,
  input  logic [RSW-1:0] cmd_sel,
  output logic           launch,
  output logic           busy,
  output logic           done,
  output logic [IW-1:0]  idx,
  output mvu_op_e        op_q,
  output logic [RSW-1:0] dst_q,
  output logic [RSW-1:0] srca_q,
  output logic [RSW-1:0] srcb_q,
  output logic [RSW-1:0] sel_q
);
  localparam logic [IW-1:0] LAST = IW'(VLEN - 1);

  assign launch = !busy && cmd_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      idx    <= '0;
      op_q   <= OP_ADD;
      dst_q  <= '0;
      srca_q <= '0;
      srcb_q <= '0;
      sel_q  <= '0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        busy   <= 1'b1;
        idx    <= '0;
        op_q   <= cmd_op;
        dst_q  <= cmd_dst;
        srca_q <= cmd_srca;
        srcb_q <= cmd_srcb;
        sel_q  <= cmd_sel;
      end else if (busy) begin
        if (idx == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mvu_lane.sv
// Single element lane: index selection, arithmetic, predication, accumulator.
module mvu_lane
  import mvu_pkg::*;
#(
  parameter int VLEN = 8,
  parameter int EW   = 16,
  parameter int AW   = 32,
  localparam int IW  = (VLEN > 1) ? $clog2(VLEN) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  mvu_op_e       launch_op,
  input  logic          active,
  input  mvu_op_e       op,
  input  logic [IW-1:0] idx,
  input  logic [EW-1:0] sel_elem,
  input  logic [EW-1:0] a_elem,
  input  logic [EW-1:0] b_elem,
  output logic [IW-1:0] src_idx,
  output logic          we,
  output logic [IW-1:0] widx,
  output logic [EW-1:0] wdata,
  output logic [AW-1:0] acc
);
  logic [2*EW-1:0] prod;
  logic [EW-1:0]   sum;
  logic [IW-1:0]   sel_idx;

  assign sel_idx = sel_elem[IW-1:0];
  assign prod    = a_elem * b_elem;
  assign sum     = a_elem + b_elem;
  assign src_idx = (op == OP_GATH) ? sel_idx : idx;
  assign widx    = (op == OP_SCAT) ? sel_idx : idx;

  always_comb begin
    wdata = sum;
    we    = active;
    unique case (op)
      OP_MUL:  wdata = prod[EW-1:0];
      OP_DOT:  we    = 1'b0;
      OP_MADD: we    = active && (sel_elem != '0);
      default: wdata = sum;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                             acc <= '0;
    else if (launch && launch_op == OP_DOT) acc <= '0;
    else if (active && op == OP_DOT)     acc <= acc + AW'(prod);
  end
endmodule

// File: rtl/mvu_top.sv
module mvu_top
  import mvu_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int VLEN  = 8,
  parameter int EW    = 16,
  parameter int AW    = 32,
  localparam int RSW  = $clog2(NREGS),
  localparam int IW   = (VLEN > 1) ? $clog2(VLEN) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_start,
  input  logic [2:0]     cmd_op,
  input  logic [RSW-1:0] cmd_dst,
  input  logic [RSW-1:0] cmd_srca,
  input  logic [RSW-1:0] cmd_srcb,
  input  logic [RSW-1:0] cmd_sel,
  output logic           busy,
  output logic           done,
  output logic [AW-1:0]  acc_out,
  input  logic           host_we,
  input  logic [RSW-1:0] host_reg,
  input  logic [IW-1:0]  host_idx,
  input  logic [EW-1:0]  host_wdata,
  output logic [EW-1:0]  host_rdata
);
  localparam int DEPTH = NREGS * VLEN;
  localparam int DAW   = RSW + IW;

  mvu_op_e        op_in, op_q;
  logic           launch;
  logic [IW-1:0]  idx, src_idx, widx;
  logic [RSW-1:0] dst_q, srca_q, srcb_q, sel_q;
  logic           eng_we;
  logic [EW-1:0]  eng_wdata;

  logic [2:0][DAW-1:0] rd_addr;
  logic [2:0][EW-1:0]  rd_data;
  logic                wr_en;
  logic [DAW-1:0]      wr_addr;
  logic [EW-1:0]       wr_data;

  assign op_in = mvu_op_e'(cmd_op);

  mvu_seq #(.VLEN(VLEN), .RSW(RSW)) u_seq (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_op(op_in),
    .cmd_dst(cmd_dst), .cmd_srca(cmd_srca), .cmd_srcb(cmd_srcb),
    .cmd_sel(cmd_sel), .launch(launch), .busy(busy), .done(done),
    .idx(idx), .op_q(op_q), .dst_q(dst_q), .srca_q(srca_q),
    .srcb_q(srcb_q), .sel_q(sel_q)
  );

  // port 0: selector element, port 1: first source (maybe gathered), port 2: second source
  assign rd_addr[0] = {sel_q, idx};
  assign rd_addr[1] = {srca_q, src_idx};
  assign rd_addr[2] = {srcb_q, idx};

  mvu_lane #(.VLEN(VLEN), .EW(EW), .AW(AW)) u_lane (
    .clk(clk), .rst(rst), .launch(launch), .launch_op(op_in),
    .active(busy), .op(op_q), .idx(idx), .sel_elem(rd_data[0]),
    .a_elem(rd_data[1]), .b_elem(rd_data[2]), .src_idx(src_idx),
    .we(eng_we), .widx(widx), .wdata(eng_wdata), .acc(acc_out)
  );

  // engine owns the write port while busy; host writes only when idle
  assign wr_en   = eng_we || (host_we && !busy);
  assign wr_addr = busy ? {dst_q, widx} : {host_reg, host_idx};
  assign wr_data = busy ? eng_wdata : host_wdata;

  mvu_vrf #(.DEPTH(DEPTH), .EW(EW), .NRD(3)) u_vrf (
    .clk(clk), .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .hr_addr({host_reg, host_idx}),
    .hr_data(host_rdata)
  );
endmodule

// File: rtl/mvu_chk.sv
module mvu_chk #(
  parameter int VLEN = 8,
  parameter int AW   = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_start,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] acc_out,
  input logic          eng_we
);
  int run_cnt;

  always_ff @(posedge clk) begin
    if (rst)       run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else           run_cnt <= 0;
  end

  p_done_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_ends_run_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(busy));
  p_run_length_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_cnt == VLEN));
  p_launch_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_start) |=> busy);
  p_idle_no_write_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !eng_we);
  p_acc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cmd_start) |=> $stable(acc_out));
endmodule

bind mvu_top mvu_chk #(.VLEN(VLEN), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cmd_start(cmd_start), .busy(busy),
  .done(done), .acc_out(acc_out), .eng_we(eng_we)
);

// File: tb/tb_mvu_top.sv
module tb_mvu_top;
  localparam int NR = 8;
  localparam int VL = 8;
  localparam logic [2:0] K_ADD = 3'd0, K_MUL = 3'd1, K_DOT = 3'd2,
                         K_MADD = 3'd3, K_SCAT = 3'd4, K_GATH = 3'd5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_start = 1'b0;
  logic [2:0]  cmd_op = '0, cmd_dst = '0, cmd_srca = '0, cmd_srcb = '0, cmd_sel = '0;
  logic        busy, done;
  logic [31:0] acc_out;
  logic        host_we = 1'b0;
  logic [2:0]  host_reg = '0, host_idx = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;

  always #5 clk = ~clk;

  mvu_top dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_dst(cmd_dst), .cmd_srca(cmd_srca), .cmd_srcb(cmd_srcb),
    .cmd_sel(cmd_sel), .busy(busy), .done(done), .acc_out(acc_out),
    .host_we(host_we), .host_reg(host_reg), .host_idx(host_idx),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  int unsigned mdl [NR][VL];
  int unsigned acc_mdl = 0;

  // scoreboard
  string       tag_q[$];
  int unsigned val_q[$];
  logic        rd_req = 1'b0;
  logic        rd_req_d = 1'b0;

  always @(posedge clk) rd_req_d <= rd_req;

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares registered host read data against queued expectations
  always @(negedge clk) begin
    if (rd_req_d) begin
      if (tag_q.size() == 0) chk("R10 unexpected read", 1, 0);
      else begin
        string       t;
        int unsigned v;
        t = tag_q.pop_front();
        v = val_q.pop_front();
        chk(t, longint'(host_rdata), longint'(v));
      end
    end
  end

  task automatic host_write(int r, int i, int unsigned v);
    @(negedge clk);
    host_we = 1'b1; host_reg = 3'(r); host_idx = 3'(i); host_wdata = 16'(v);
    mdl[r][i] = v & 32'hFFFF;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic exp_read(int r, int i, string tag);
    @(negedge clk);
    host_reg = 3'(r); host_idx = 3'(i); rd_req = 1'b1;
    tag_q.push_back(tag);
    val_q.push_back(mdl[r][i]);
  endtask

  task automatic end_reads();
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_vec(int r, string tag);
    for (int i = 0; i < VL; i++) exp_read(r, i, tag);
    end_reads();
  endtask

  task automatic model_op(logic [2:0] op, int d, int a, int b, int s);
    if (op == K_DOT) acc_mdl = 0;
    for (int i = 0; i < VL; i++) begin
      int unsigned m, av, bv;
      int si, di;
      m  = mdl[s][i];
      si = (op == K_GATH) ? int'(m % VL) : i;
      di = (op == K_SCAT) ? int'(m % VL) : i;
      av = mdl[a][si];
      bv = mdl[b][i];
      case (op)
        K_MUL:  mdl[d][i] = (av * bv) & 32'hFFFF;
        K_DOT:  acc_mdl = acc_mdl + av * bv;
        K_MADD: if (m != 0) mdl[d][i] = (av + bv) & 32'hFFFF;
        default: mdl[d][di] = (av + bv) & 32'hFFFF;
      endcase
    end
  endtask

  // launch, time the run, optionally poke start and host write mid-run
  task automatic run_op(logic [2:0] op, int d, int a, int b, int s, bit poke);
    int k;
    @(negedge clk);
    cmd_op = op; cmd_dst = 3'(d); cmd_srca = 3'(a); cmd_srcb = 3'(b); cmd_sel = 3'(s);
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    chk("R8 busy after launch", longint'(busy), 1);
    k = 1;
    while (!done && k < 100) begin
      if (poke && k == 3) begin
        cmd_start = 1'b1; cmd_op = K_ADD; cmd_dst = 3'd7; cmd_srca = 3'd0; cmd_srcb = 3'd1;
        host_we = 1'b1; host_reg = 3'd6; host_idx = 3'd0; host_wdata = 16'hDEAD;
      end else begin
        cmd_start = 1'b0; host_we = 1'b0;
      end
      @(negedge clk);
      if (!done) begin
        if (!busy) chk("R8 busy held", 0, 1);
        k++;
      end
    end
    cmd_start = 1'b0; host_we = 1'b0;
    chk("R8 busy length", k, VL);
    chk("R8 done high", longint'(done), 1);
    chk("R8 busy low at done", longint'(busy), 0);
    @(negedge clk);
    chk("R8 done single pulse", longint'(done), 0);
    model_op(op, d, a, b, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned idxv [VL];
    int unsigned mskv [VL];
    idxv = '{3, 11, 0, 19, 7, 15, 2, 1};
    mskv = '{0, 5, 0, 0, 1, 0, 9, 0};
    repeat (3) @(negedge clk);
    chk("R11 busy reset", longint'(busy), 0);
    chk("R11 done reset", longint'(done), 0);
    chk("R11 acc reset", longint'(acc_out), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 idle after reset", longint'(busy), 0);

    for (int i = 0; i < VL; i++) begin
      host_write(0, i, (i * 9000 + 60000) & 32'hFFFF);
      host_write(1, i, (i * 7777 + 50000) & 32'hFFFF);
      host_write(2, i, mskv[i]);
      host_write(3, i, idxv[i]);
      host_write(4, i, 100 + i);
      host_write(5, i, 200 + i);
      host_write(6, i, 300 + i);
      host_write(7, i, 400 + i);
    end
    check_vec(3, "R10 host readback");

    run_op(K_ADD, 4, 0, 1, 2, 0);
    check_vec(4, "R1 add");

    run_op(K_MUL, 5, 0, 1, 2, 0);
    check_vec(5, "R2 mul");

    run_op(K_DOT, 6, 0, 1, 2, 0);
    chk("R3 dot sum", longint'(acc_out), longint'(acc_mdl));
    check_vec(6, "R3 dot writes nothing");

    run_op(K_MADD, 4, 1, 5, 2, 0);
    check_vec(4, "R4 masked add");

    run_op(K_SCAT, 6, 0, 1, 3, 0);
    check_vec(6, "R5 R6 scatter");
    exp_read(6, 3, "R6 collision at 3");
    exp_read(6, 7, "R6 collision at 7");
    exp_read(6, 5, "R5 untouched position");
    end_reads();

    run_op(K_GATH, 5, 0, 1, 3, 0);
    check_vec(5, "R7 gather");

    run_op(K_ADD, 4, 0, 5, 2, 1);
    check_vec(4, "R9 run unaffected");
    check_vec(7, "R9 ignored start");
    exp_read(6, 0, "R10 busy host write ignored");
    end_reads();

    chk("R3 acc held by other ops", longint'(acc_out), longint'(acc_mdl));
    chk("R10 scoreboard drained", tag_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule